// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Memory Port

This block is a small byte-addressed storage array with a single CPU-facing access port. Each request moves a byte, a 16-bit halfword or a 32-bit word. A multi-byte value occupies consecutive byte addresses starting at the request address. A mode input chooses, request by request, whether the most significant or the least significant byte of the value sits at that starting address.

A request is a cycle with the select input high. The read/write input then picks a store or a load. Stores update the array on the rising clock edge. Load results are registered and appear one cycle after the request, zero-extended to 32 bits. Each request is checked for natural alignment. A misaligned request is not carried out. Instead, a fault flag is raised for one cycle, the read data register is cleared, and the array is left untouched.

Top module: `endian_mem_port`

## Requirements
- R1: While rst_ni is low, rdata_o is 0 and fault_o is 0.
- R2: When sel_i is low, no byte of the array changes, rdata_o keeps its value and fault_o is 0 in the next cycle.
- R3: With sel_i high, rd_i = 0 stores and rd_i = 1 loads. A store updates the array at the clock edge and leaves rdata_o unchanged. A load's result is on rdata_o from the cycle after the request.
- R4: size_i encodes 2'b00 byte, 2'b01 halfword and 2'b10 word. A halfword at address Z covers bytes Z and Z+1. A word at Z covers bytes Z to Z+3.
- R5: A halfword needs addr_i[0] = 0 and a word needs addr_i[1:0] = 0. Byte requests are always aligned. size_i = 2'b11 is always treated as misaligned.
- R6: With big_endian_i = 1, the most significant byte of the value is at address Z. Storing word 0x01020304 at Z gives bytes 01,02,03,04 at Z..Z+3. Storing halfword 0x0A0B at W gives 0A,0B at W,W+1.
- R7: With big_endian_i = 0, the least significant byte is at address Z. Storing word 0x01020304 at Z gives bytes 04,03,02,01 at Z..Z+3. Storing halfword 0x0A0B at W gives 0B,0A at W,W+1.
- R8: A misaligned request, whether load or store, sets fault_o for exactly the next cycle and changes no byte of the array. fault_o is never high except in the cycle after a misaligned request.
- R9: Any misaligned request sets rdata_o to 0 in the next cycle.
- R10: Byte loads return the byte in rdata_o[7:0] and halfword loads return it in rdata_o[15:0], with all upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Request valid in this cycle |
| rd_i | input | 1 | 1 load, 0 store |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| big_endian_i | input | 1 | 1 places MSB at the lowest address, 0 places LSB there |
| addr_i | input | ADDR_W | Byte address of the request |
| wdata_i | input | 32 | Store value, right-aligned |
| rdata_o | output | 32 | Registered, zero-extended load result |
| fault_o | output | 1 | One-cycle misalignment flag |

## Verification
The hardest case to expose from the ports is a byte-order error that appears symmetrically on both the store and the load path. A design that reverses the lanes on both paths still returns whatever a matching-mode store wrote. The stimulus therefore stores in one mode and reads back with a different size or the other mode, for example byte loads after a word store or a word load in the opposite order. A long mixed sequence of sizes, orders, offsets and misaligned requests is compared against a byte-level model in the bench.

// File: rtl/emp_pkg.sv
package emp_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  function automatic logic [2:0] size_bytes(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      SZ_WORD: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/emp_align_check.sv
module emp_align_check
  import emp_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] off_i,
  output logic       misalign_o
);
  always_comb begin
    case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      SZ_WORD: misalign_o = |off_i;
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/emp_lane_steer.sv
module emp_lane_steer
  import emp_pkg::*;
(
  input  logic [1:0]          size_i,
  input  logic                big_endian_i,
  input  logic [1:0]          off_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [LANES-1:0]    lane_we_o,
  output logic [DATA_W-1:0]   lane_wdata_o
);
  logic [2:0] nbytes;
  assign nbytes = size_bytes(size_i);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [2:0] rel3;
    logic [1:0] rel2;
    logic [1:0] src;
    assign rel3 = 3'(k) - {1'b0, off_i};
    assign rel2 = 2'(k) - off_i;
    // value byte index feeding this lane
    assign src  = big_endian_i ? (nbytes[1:0] - 2'd1 - rel2) : rel2;
    assign lane_we_o[k] = (rel3 < nbytes);
    assign lane_wdata_o[k*8 +: 8] = wdata_i[{src, 3'b000} +: 8];
  end
endmodule

// File: rtl/emp_byte_bank.sv
module emp_byte_bank
  import emp_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int WORDS = 2 ** IDX_W
) (
  input  logic                clk_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [LANES-1:0]    we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i[k]) mem[idx_i] <= wdata_i[k*8 +: 8];
    end
    assign rdata_o[k*8 +: 8] = mem[idx_i];
  end
endmodule

// File: rtl/emp_read_merge.sv
module emp_read_merge
  import emp_pkg::*;
(
  input  logic [1:0]          size_i,
  input  logic                big_endian_i,
  input  logic [1:0]          off_i,
  input  logic [DATA_W-1:0]   lanes_i,
  output logic [DATA_W-1:0]   data_o
);
  logic [2:0] nbytes;
  assign nbytes = size_bytes(size_i);

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    logic [1:0] lane;
    assign lane = off_i + (big_endian_i ? (nbytes[1:0] - 2'd1 - 2'(j)) : 2'(j));
    // bytes beyond the access size are zero
    assign data_o[j*8 +: 8] = (3'(j) < nbytes) ? lanes_i[{lane, 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port
  import emp_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [1:0]        size_i,
  input  logic              big_endian_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              fault_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [1:0]        off;
  logic [IDX_W-1:0]  idx;
  logic              misalign;
  logic              do_write;
  logic [LANES-1:0]  steer_we;
  logic [DATA_W-1:0] steer_data;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rdata_q;
  logic              fault_q;

  assign off = addr_i[1:0];
  assign idx = addr_i[ADDR_W-1:2];

  emp_align_check u_align (
    .size_i     (size_i),
    .off_i      (off),
    .misalign_o (misalign)
  );

  emp_lane_steer u_steer (
    .size_i       (size_i),
    .big_endian_i (big_endian_i),
    .off_i        (off),
    .wdata_i      (wdata_i),
    .lane_we_o    (steer_we),
    .lane_wdata_o (steer_data)
  );

  assign do_write = sel_i & ~rd_i & ~misalign;

  emp_byte_bank #(.IDX_W(IDX_W)) u_bank (
    .clk_i   (clk_i),
    .idx_i   (idx),
    .we_i    (steer_we & {LANES{do_write}}),
    .wdata_i (steer_data),
    .rdata_o (bank_rd)
  );

  emp_read_merge u_merge (
    .size_i       (size_i),
    .big_endian_i (big_endian_i),
    .off_i        (off),
    .lanes_i      (bank_rd),
    .data_o       (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= sel_i & misalign;
      if (sel_i & misalign)  rdata_q <= '0;
      else if (sel_i & rd_i) rdata_q <= merged;
    end
  end

  assign rdata_o = rdata_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/endian_mem_port_chk.sv
module endian_mem_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              rd_i,
  input logic [1:0]        size_i,
  input logic              big_endian_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              fault_o
);
  logic bad;
  always_comb begin
    case (size_i)
      2'b00:   bad = 1'b0;
      2'b01:   bad = addr_i[0];
      2'b10:   bad = addr_i[1] | addr_i[0];
      default: bad = 1'b1;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (rdata_o == 32'h0 && !fault_o));

  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> ($stable(rdata_o) && !fault_o));

  assert_store_holds_rdata_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !rd_i && !bad) |=> $stable(rdata_o));

  assert_fault_raised_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && bad) |=> fault_o);

  assert_fault_only_when_due_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && bad) |=> !fault_o);

  assert_misalign_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && bad) |=> (rdata_o == 32'h0));

  assert_byte_zext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && size_i == 2'b00) |=> (rdata_o[31:8] == 24'h0));

  assert_half_zext_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && size_i == 2'b01) |=> (rdata_o[31:16] == 16'h0));

  logic unused_ok;
  assign unused_ok = ^{big_endian_i, wdata_i};
endmodule

bind endian_mem_port endian_mem_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_endian_mem_port.sv
module tb_endian_mem_port;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 2 ** ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              sel_i = 1'b0;
  logic              rd_i = 1'b0;
  logic [1:0]        size_i = 2'b00;
  logic              big_endian_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic              fault_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0]  ref_mem [NBYTES];
  logic [31:0] got_d;
  logic        got_f;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk_i = ~clk_i;

  endian_mem_port #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  function automatic logic misal(input logic [1:0] sz, input logic [ADDR_W-1:0] a);
    return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
  endfunction

  function automatic logic [31:0] model_rd(input logic [1:0] sz, input logic be,
                                           input logic [ADDR_W-1:0] a);
    logic [31:0] r = '0;
    int n = nb(sz);
    for (int j = 0; j < n; j++)
      r[j*8 +: 8] = ref_mem[int'(a) + (be ? n - 1 - j : j)];
    return r;
  endfunction

  task automatic model_wr(input logic [1:0] sz, input logic be,
                          input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int n = nb(sz);
    for (int j = 0; j < n; j++)
      ref_mem[int'(a) + (be ? n - 1 - j : j)] = d[j*8 +: 8];
  endtask

  // one request, result sampled at the negedge after the active edge
  task automatic acc(input logic s, input logic rd, input logic [1:0] sz, input logic be,
                     input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = s; rd_i = rd; size_i = sz; big_endian_i = be; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    got_d = rdata_o; got_f = fault_o;
    sel_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 rdata in reset", rdata_o, 32'h0);
    check("R1 fault in reset", {31'h0, fault_o}, 32'h0);
    rst_ni = 1'b1;
    for (int w = 0; w < NBYTES / 4; w++) begin
      acc(1, 0, 2'b10, 0, ADDR_W'(w * 4), 32'h0);
      model_wr(2'b10, 0, ADDR_W'(w * 4), 32'h0);
    end
  endtask

  task automatic t_big_endian;
    acc(1, 0, 2'b10, 1, 6'd8, 32'h0102_0304);
    model_wr(2'b10, 1, 6'd8, 32'h0102_0304);
    for (int i = 0; i < 4; i++) begin
      acc(1, 1, 2'b00, 1, ADDR_W'(8 + i), 32'h0);
      check("R6 BE word byte order", got_d, 32'(i + 1));
    end
    acc(1, 1, 2'b10, 0, 6'd8, 32'h0);
    check("R7 LE reread of BE word", got_d, 32'h0403_0201);
    acc(1, 0, 2'b01, 1, 6'd20, 32'hFFFF_0A0B);
    acc(1, 1, 2'b00, 0, 6'd20, 32'h0);
    check("R6 BE half low addr", got_d, 32'h0A);
    acc(1, 1, 2'b00, 0, 6'd21, 32'h0);
    check("R6 BE half high addr", got_d, 32'h0B);
    model_wr(2'b01, 1, 6'd20, 32'h0A0B);
    acc(1, 1, 2'b01, 1, 6'd20, 32'h0);
    check("R10 BE half zero-extended", got_d, 32'h0000_0A0B);
  endtask

  task automatic t_little_endian;
    acc(1, 0, 2'b10, 0, 6'd12, 32'h0102_0304);
    model_wr(2'b10, 0, 6'd12, 32'h0102_0304);
    for (int i = 0; i < 4; i++) begin
      acc(1, 1, 2'b00, 1, ADDR_W'(12 + i), 32'h0);
      check("R7 LE word byte order", got_d, 32'(4 - i));
    end
    acc(1, 0, 2'b01, 0, 6'd22, 32'h0A0B);
    model_wr(2'b01, 0, 6'd22, 32'h0A0B);
    acc(1, 1, 2'b01, 1, 6'd22, 32'h0);
    check("R7 LE half read as BE", got_d, 32'h0000_0B0A);
    acc(1, 0, 2'b00, 0, 6'd33, 32'hDEAD_BE5A);
    model_wr(2'b00, 0, 6'd33, 32'h5A);
    acc(1, 1, 2'b10, 0, 6'd32, 32'h0);
    check("R4 byte store lands in one lane", got_d, 32'h0000_5A00);
    acc(1, 1, 2'b00, 1, 6'd33, 32'h0);
    check("R10 byte zero-extended", got_d, 32'h0000_005A);
  endtask

  task automatic t_misalign;
    acc(1, 1, 2'b10, 0, 6'd8, 32'h0);
    acc(1, 0, 2'b01, 0, 6'd9, 32'hFFFF_FFFF);
    check("R8 fault on odd half store", {31'h0, got_f}, 32'h1);
    check("R9 rdata cleared on misaligned store", got_d, 32'h0);
    acc(1, 1, 2'b10, 1, 6'd8, 32'h0);
    check("R8 array unchanged after misaligned store", got_d, 32'h0102_0304);
    check("R8 fault lasts one cycle", {31'h0, got_f}, 32'h0);
    acc(1, 1, 2'b10, 1, 6'd14, 32'h0);
    check("R5 word at offset 2 faults", {31'h0, got_f}, 32'h1);
    check("R9 misaligned load returns 0", got_d, 32'h0);
    acc(1, 1, 2'b11, 0, 6'd0, 32'h0);
    check("R5 reserved size faults", {31'h0, got_f}, 32'h1);
    acc(1, 1, 2'b00, 0, 6'd7, 32'h0);
    check("R5 odd byte address is aligned", {31'h0, got_f}, 32'h0);
  endtask

  task automatic t_deselect;
    acc(1, 1, 2'b10, 1, 6'd8, 32'h0);
    acc(0, 0, 2'b10, 1, 6'd8, 32'hCAFE_F00D);
    check("R2 idle keeps rdata", got_d, 32'h0102_0304);
    check("R2 idle no fault", {31'h0, got_f}, 32'h0);
    acc(0, 1, 2'b10, 1, 6'd12, 32'h0);
    check("R2 idle read ignored", got_d, 32'h0102_0304);
    acc(1, 0, 2'b10, 1, 6'd12, 32'h1111_2222);
    model_wr(2'b10, 1, 6'd12, 32'h1111_2222);
    check("R3 store leaves rdata", got_d, 32'h0102_0304);
    acc(1, 1, 2'b10, 1, 6'd8, 32'h0);
    check("R2 array unchanged by idle store", got_d, 32'h0102_0304);
    acc(1, 1, 2'b10, 0, 6'd12, 32'h0);
    check("R3 store visible on next load", got_d, 32'h2222_1111);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      logic be, rd, bad;
      logic [ADDR_W-1:0] a;
      logic [31:0] d, exp_d, prev;
      seed = seed * 32'd1103515245 + 32'd12345;
      sz = (seed[20:17] == 4'hF) ? 2'b11 : 2'(seed[19:16] % 3);
      be = seed[21]; rd = seed[22];
      a  = seed[28:23];
      if (seed[29] && !seed[30]) a = (sz == 2'b10) ? {a[ADDR_W-1:2], 2'b00} :
                                     (sz == 2'b01) ? {a[ADDR_W-1:1], 1'b0} : a;
      d  = seed ^ {seed[15:0], seed[31:16]};
      bad = misal(sz, a);
      prev = got_d;
      exp_d = bad ? 32'h0 : rd ? model_rd(sz, be, a) : prev;
      acc(1, rd, sz, be, a, d);
      if (!bad && !rd) model_wr(sz, be, a, d);
      check(bad ? "R9 sweep misaligned data" : rd ? "R6 R7 sweep load" : "R3 sweep store",
            got_d, exp_d);
      check("R8 sweep fault", {31'h0, got_f}, {31'h0, bad});
    end
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    t_reset();
    t_big_endian();
    t_little_endian();
    t_misalign();
    t_deselect();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule